// File: doc/BRIEF.md
# Dual-Issue Pipe Dispatch Router

This block sits between a two-wide decode stage and four execution pipes: a complex integer pipe (I), a simple integer pipe (J), a load/store pipe (L) and a floating-point pipe (F). Each cycle up to two decoded instructions arrive, one per issue slot. Each carries a three-bit class tag. The router also sees one busy flag per pipe dispatch stage. From these it decides which slot goes to which pipe and raises a per-slot accept in the same cycle. An instruction whose accept stays low is held upstream and offered again on the next cycle.

The routing rules are these. Simple integer work may use either integer pipe. Complex integer work, loads and stores, and floating-point work each have a single home pipe. An atomic reserve or conditional store must sit in the first slot and needs the I and L dispatch stages together. A context-synchronizing instruction claims I, L and F together. Slot 0 always claims before slot 1. Slot 1 is accepted only when slot 0 is accepted in the same cycle, so program order is kept.

One cycle after acceptance, the claimed pipes see a registered dispatch strobe. Each strobe comes with the index of the slot that feeds that pipe.

Top module: `dual_dispatch_router`

## Requirements
- R1: A slot is accepted only when it is valid and every pipe it is granted was not busy in that cycle. Pipe bits are I=0, J=1, L=2, F=3 in `pipe_busy`, `disp_go` and `disp_src`.
- R2: Class code 0 (simple integer) takes the J pipe when J is free, takes the I pipe when J is not free, and is rejected when neither is available.
- R3: Class code 1 (complex integer) needs only I. Class code 2 (load/store) needs only L. Class code 3 (floating point) needs only F.
- R4: Class code 4 (atomic) needs I and L free in the same cycle and claims both. It is never accepted from slot 1.
- R5: Class code 5 (synchronizing) needs I, L and F free in the same cycle and claims all three. The state of J does not matter to it.
- R6: When both slots want the same pipe, slot 0 gets it. Slot 1 then falls back to the other integer pipe if it is a simple integer operation and that pipe is free; otherwise slot 1 is rejected.
- R7: Slot 1 is accepted only in a cycle where slot 0 is accepted. This includes the case where slot 0 is not valid.
- R8: Class codes 6 and 7 are reserved and are never accepted.
- R9: On the clock edge that ends an accepting cycle, `disp_go` sets exactly the claimed pipe bits, and `disp_src` bit p holds the index of the slot that claimed pipe p. After a cycle with no acceptance, `disp_go` is zero.
- R10: While `rst_n` is low, `slot_acc` and `disp_go` are zero. After `rst_n` is released, acceptance stays off through the first rising clock edge and begins after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_vld | input | 2 | Valid flag per issue slot (bit 0 = slot 0) |
| slot_cls | input | 6 | Class tag per slot, 3 bits each, slot 0 in bits 2:0 |
| pipe_busy | input | 4 | Busy flag per pipe dispatch stage (I, J, L, F = bits 0..3) |
| slot_acc | output | 2 | Per-slot accept for this cycle |
| disp_go | output | 4 | Registered dispatch strobe per pipe |
| disp_src | output | 4 | Registered source-slot index per pipe, 1 bit per pipe |

## Verification
A stimulus table pairs class tags for each slot with busy masks. The pairs are chosen to tell apart the outcomes of the routing: the preferred integer pipe against the fallback, a slot-0 win against slot 1 stealing a pipe, and an accepted younger slot against one held back by an older slot that stalled. Atomic and synchronizing classes are tried with exactly one of their needed pipes busy, which shows that all of their pipes are needed together. They are also tried with J busy, which shows that J is ignored. Directed sequences cover acceptance held off during and after reset release, and a reset asserted in the middle of a cycle that clears the strobes at once.

// File: rtl/disp_router_pkg.sv
package disp_router_pkg;

  localparam int NUM_PIPES = 4;
  localparam int CLS_W     = 3;

  localparam int PIPE_I = 0;
  localparam int PIPE_J = 1;
  localparam int PIPE_L = 2;
  localparam int PIPE_F = 3;

  typedef logic [NUM_PIPES-1:0] pipe_mask_t;

  localparam pipe_mask_t MASK_NONE = '0;
  localparam pipe_mask_t MASK_I    = pipe_mask_t'(1) << PIPE_I;
  localparam pipe_mask_t MASK_J    = pipe_mask_t'(1) << PIPE_J;
  localparam pipe_mask_t MASK_L    = pipe_mask_t'(1) << PIPE_L;
  localparam pipe_mask_t MASK_F    = pipe_mask_t'(1) << PIPE_F;

  typedef enum logic [CLS_W-1:0] {
    CLS_SIMPLE  = 3'd0,
    CLS_COMPLEX = 3'd1,
    CLS_MEM     = 3'd2,
    CLS_FLOAT   = 3'd3,
    CLS_ATOMIC  = 3'd4,
    CLS_SYNC    = 3'd5,
    CLS_RSV6    = 3'd6,
    CLS_RSV7    = 3'd7
  } insn_cls_e;

  // What one class asks of the dispatch stages.
  typedef struct packed {
    logic       legal;
    logic       first_only;
    pipe_mask_t need;   // pipes that must all be free
    pipe_mask_t alt;    // fallback set, empty when there is none
  } route_need_t;

endpackage

// File: rtl/dr_reset_sync.sv
module dr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/dr_class_decode.sv
module dr_class_decode
  import disp_router_pkg::*;
#(
  parameter bit PREFER_J = 1'b1
) (
  input  logic [CLS_W-1:0] cls,
  output route_need_t      info
);
  localparam pipe_mask_t SIMPLE_PRI = PREFER_J ? MASK_J : MASK_I;
  localparam pipe_mask_t SIMPLE_ALT = PREFER_J ? MASK_I : MASK_J;

  always_comb begin
    info = '{legal: 1'b1, first_only: 1'b0, need: MASK_NONE, alt: MASK_NONE};
    case (insn_cls_e'(cls))
      CLS_SIMPLE: begin
        info.need = SIMPLE_PRI;
        info.alt  = SIMPLE_ALT;
      end
      CLS_COMPLEX: info.need = MASK_I;
      CLS_MEM:     info.need = MASK_L;
      CLS_FLOAT:   info.need = MASK_F;
      CLS_ATOMIC: begin
        info.need       = MASK_I | MASK_L;
        info.first_only = 1'b1;
      end
      CLS_SYNC:    info.need = MASK_I | MASK_L | MASK_F;
      default:     info.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dr_slot_alloc.sv
module dr_slot_alloc
  import disp_router_pkg::*;
#(
  parameter bit IS_FIRST = 1'b0
) (
  input  logic        vld,
  input  logic        prior_ok,
  input  pipe_mask_t  avail,
  input  route_need_t info,
  output logic        acc,
  output pipe_mask_t  take
);
  logic may_go;
  logic fits_need;
  logic fits_alt;
  logic use_need;
  logic use_alt;

  always_comb begin
    may_go    = vld && prior_ok && info.legal && (IS_FIRST || !info.first_only);
    fits_need = (info.need & ~avail) == MASK_NONE;
    fits_alt  = (info.alt != MASK_NONE) && ((info.alt & ~avail) == MASK_NONE);
    use_need  = may_go && fits_need;
    use_alt   = may_go && !fits_need && fits_alt;
    acc       = use_need || use_alt;
    if (use_need)     take = info.need;
    else if (use_alt) take = info.alt;
    else              take = MASK_NONE;
  end
endmodule

// File: rtl/dr_dispatch_reg.sv
module dr_dispatch_reg
  import disp_router_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int SW        = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SLOTS*NUM_PIPES-1:0] take_all,
  output logic [NUM_PIPES-1:0]           disp_go,
  output logic [NUM_PIPES*SW-1:0]        disp_src
);
  logic [NUM_PIPES-1:0]    go_nxt;
  logic [NUM_PIPES*SW-1:0] src_nxt;

  always_comb begin
    go_nxt  = '0;
    src_nxt = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < NUM_PIPES; p++) begin
        if (take_all[s*NUM_PIPES+p]) begin
          go_nxt[p]            = 1'b1;
          src_nxt[p*SW +: SW]  = SW'(s);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_go <= '0;
    else        disp_go <= go_nxt;
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         disp_src[p*SW +: SW] <= '0;
      else if (go_nxt[p]) disp_src[p*SW +: SW] <= src_nxt[p*SW +: SW];
    end
  end
endmodule

// File: rtl/dual_dispatch_router.sv
module dual_dispatch_router
  import disp_router_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter bit PREFER_J  = 1'b1,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS-1:0]       slot_vld,
  input  logic [NUM_SLOTS*CLS_W-1:0] slot_cls,
  input  logic [NUM_PIPES-1:0]       pipe_busy,
  output logic [NUM_SLOTS-1:0]       slot_acc,
  output logic [NUM_PIPES-1:0]       disp_go,
  output logic [NUM_PIPES*SW-1:0]    disp_src
);
  logic                           rst_sync_n;
  logic [NUM_SLOTS-1:0]           prior_ok;
  logic [NUM_SLOTS*NUM_PIPES-1:0] avail_in;
  logic [NUM_SLOTS*NUM_PIPES-1:0] take_all;

  dr_reset_sync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    route_need_t info;

    if (s == 0) begin : g_head
      assign avail_in[0 +: NUM_PIPES] = ~pipe_busy;
      assign prior_ok[0]              = rst_sync_n;
    end else begin : g_tail
      // Younger slot sees only what older slots left, and only if they all went.
      assign avail_in[s*NUM_PIPES +: NUM_PIPES] =
        avail_in[(s-1)*NUM_PIPES +: NUM_PIPES] & ~take_all[(s-1)*NUM_PIPES +: NUM_PIPES];
      assign prior_ok[s] = prior_ok[s-1] & slot_acc[s-1];
    end

    dr_class_decode #(.PREFER_J(PREFER_J)) u_dec (
      .cls  (slot_cls[s*CLS_W +: CLS_W]),
      .info (info)
    );

    dr_slot_alloc #(.IS_FIRST(s == 0)) u_alloc (
      .vld      (slot_vld[s]),
      .prior_ok (prior_ok[s]),
      .avail    (avail_in[s*NUM_PIPES +: NUM_PIPES]),
      .info     (info),
      .acc      (slot_acc[s]),
      .take     (take_all[s*NUM_PIPES +: NUM_PIPES])
    );
  end

  dr_dispatch_reg #(.NUM_SLOTS(NUM_SLOTS), .SW(SW)) u_dreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .take_all (take_all),
    .disp_go  (disp_go),
    .disp_src (disp_src)
  );
endmodule

// File: rtl/dr_router_chk.sv
module dr_router_chk
  import disp_router_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SLOTS-1:0]       slot_vld,
  input logic [NUM_SLOTS*CLS_W-1:0] slot_cls,
  input logic [NUM_PIPES-1:0]       pipe_busy,
  input logic [NUM_SLOTS-1:0]       slot_acc,
  input logic [NUM_PIPES-1:0]       disp_go
);
  assert_busy_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_acc) |=> ((disp_go & $past(pipe_busy)) == '0));

  assert_idle_no_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|slot_acc) |=> (disp_go == '0));

  assert_sync_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_acc[0] && slot_cls[CLS_W-1:0] == CLS_SYNC)
      |=> (disp_go[PIPE_I] && disp_go[PIPE_L] && disp_go[PIPE_F]));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    assert_valid_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_acc[s] |-> slot_vld[s]);

    assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cls[s*CLS_W +: CLS_W] == CLS_RSV6 || slot_cls[s*CLS_W +: CLS_W] == CLS_RSV7)
        |-> !slot_acc[s]);

    if (s > 0) begin : g_young
      assert_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_acc[s] |-> slot_acc[s-1]);

      assert_atomic_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cls[s*CLS_W +: CLS_W] == CLS_ATOMIC) |-> !slot_acc[s]);
    end
  end
endmodule

bind dual_dispatch_router dr_router_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_vld  (slot_vld),
  .slot_cls  (slot_cls),
  .pipe_busy (pipe_busy),
  .slot_acc  (slot_acc),
  .disp_go   (disp_go)
);

// File: tb/sim_dual_dispatch_router.sv
module sim_dual_dispatch_router;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  typedef struct packed {
    logic [1:0] vld;
    logic [2:0] c0;
    logic [2:0] c1;
    logic [3:0] busy;
    logic [1:0] acc;
    logic [3:0] go;
    logic [3:0] src;
    logic [7:0] req;
  } vec_t;

  // Class codes: 0 simple, 1 complex, 2 mem, 3 float, 4 atomic, 5 sync, 6/7 reserved.
  // Pipe bits: I=0 J=1 L=2 F=3.
  localparam vec_t VEC [NV] = '{
    '{2'b01, 3'd0, 3'd0, 4'b0000, 2'b01, 4'b0010, 4'b0000, 8'd2},  // R2 prefers J
    '{2'b01, 3'd0, 3'd0, 4'b0010, 2'b01, 4'b0001, 4'b0000, 8'd2},  // R2 fallback to I
    '{2'b01, 3'd0, 3'd0, 4'b0011, 2'b00, 4'b0000, 4'b0000, 8'd2},  // R2 both integer pipes busy
    '{2'b11, 3'd0, 3'd0, 4'b0000, 2'b11, 4'b0011, 4'b0001, 8'd6},  // R6 slot1 falls back to I
    '{2'b11, 3'd1, 3'd0, 4'b0000, 2'b11, 4'b0011, 4'b0010, 8'd3},  // R3 complex on I, simple on J
    '{2'b11, 3'd1, 3'd1, 4'b0000, 2'b01, 4'b0001, 4'b0000, 8'd6},  // R6 slot0 wins I
    '{2'b11, 3'd2, 3'd3, 4'b0000, 2'b11, 4'b1100, 4'b1000, 8'd3},  // R3 mem on L, float on F
    '{2'b11, 3'd2, 3'd2, 4'b0000, 2'b01, 4'b0100, 4'b0000, 8'd6},  // R6 both want L
    '{2'b11, 3'd3, 3'd2, 4'b0100, 2'b01, 4'b1000, 4'b0000, 8'd1},  // R1 slot1 L busy
    '{2'b11, 3'd2, 3'd3, 4'b0100, 2'b00, 4'b0000, 4'b0000, 8'd7},  // R7 slot0 stalls, slot1 held
    '{2'b10, 3'd0, 3'd3, 4'b0000, 2'b00, 4'b0000, 4'b0000, 8'd7},  // R7 slot0 not valid
    '{2'b01, 3'd4, 3'd0, 4'b0000, 2'b01, 4'b0101, 4'b0000, 8'd4},  // R4 atomic claims I and L
    '{2'b01, 3'd4, 3'd0, 4'b0100, 2'b00, 4'b0000, 4'b0000, 8'd4},  // R4 atomic, L busy
    '{2'b01, 3'd4, 3'd0, 4'b0001, 2'b00, 4'b0000, 4'b0000, 8'd4},  // R4 atomic, I busy
    '{2'b11, 3'd0, 3'd4, 4'b0000, 2'b01, 4'b0010, 4'b0000, 8'd4},  // R4 atomic in slot1 refused
    '{2'b01, 3'd5, 3'd0, 4'b0010, 2'b01, 4'b1101, 4'b0000, 8'd5},  // R5 sync ignores J
    '{2'b01, 3'd5, 3'd0, 4'b1000, 2'b00, 4'b0000, 4'b0000, 8'd5},  // R5 sync, F busy
    '{2'b11, 3'd5, 3'd0, 4'b0000, 2'b11, 4'b1111, 4'b0010, 8'd5},  // R5 sync plus simple on J
    '{2'b11, 3'd5, 3'd1, 4'b0000, 2'b01, 4'b1101, 4'b0000, 8'd6},  // R6 complex after sync
    '{2'b01, 3'd6, 3'd0, 4'b0000, 2'b00, 4'b0000, 4'b0000, 8'd8},  // R8 reserved code 6
    '{2'b11, 3'd1, 3'd7, 4'b0000, 2'b01, 4'b0001, 4'b0000, 8'd8},  // R8 reserved code 7 in slot1
    '{2'b11, 3'd4, 3'd3, 4'b0000, 2'b11, 4'b1101, 4'b1000, 8'd9},  // R9 source index per pipe
    '{2'b11, 3'd0, 3'd1, 4'b0010, 2'b01, 4'b0001, 4'b0000, 8'd6},  // R6 slot0 fallback takes I
    '{2'b11, 3'd0, 3'd0, 4'b0001, 2'b01, 4'b0010, 4'b0000, 8'd6},  // R6 slot1 has no pipe left
    '{2'b00, 3'd0, 3'd0, 4'b0000, 2'b00, 4'b0000, 4'b0000, 8'd9}   // R9 idle gives no strobe
  };

  logic       clk;
  logic       rst_n;
  logic [1:0] slot_vld;
  logic [5:0] slot_cls;
  logic [3:0] pipe_busy;
  logic [1:0] slot_acc;
  logic [3:0] disp_go;
  logic [3:0] disp_src;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dual_dispatch_router u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_vld  (slot_vld),
    .slot_cls  (slot_cls),
    .pipe_busy (pipe_busy),
    .slot_acc  (slot_acc),
    .disp_go   (disp_go),
    .disp_src  (disp_src)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [1:0] v, input logic [2:0] c0, input logic [2:0] c1,
                       input logic [3:0] b);
    slot_vld  = v;
    slot_cls  = {c1, c0};
    pipe_busy = b;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(2'b01, 3'd0, 3'd0, 4'b0000);
    repeat (3) @(negedge clk);
    // R10 reset holds everything off
    chk("R10 acc in reset", {6'd0, slot_acc}, 8'h00);
    chk("R10 go in reset", {4'd0, disp_go}, 8'h00);

    rst_n = 1'b1;
    #1 chk("R10 acc at release", {6'd0, slot_acc}, 8'h00);
    @(negedge clk);
    chk("R10 acc after first edge", {6'd0, slot_acc}, 8'h00);
    @(negedge clk);
    chk("R10 acc after second edge", {6'd0, slot_acc}, 8'h01);
    chk("R10 go still clear", {4'd0, disp_go}, 8'h00);
    @(negedge clk);
    chk("R10 first strobe", {4'd0, disp_go}, 8'h02);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].vld, VEC[i].c0, VEC[i].c1, VEC[i].busy);
      #(CLK_PERIOD/4);
      chk($sformatf("R%0d vec%0d acc", VEC[i].req, i), {6'd0, slot_acc}, {6'd0, VEC[i].acc});
      @(negedge clk);
      chk($sformatf("R%0d vec%0d go", VEC[i].req, i), {4'd0, disp_go}, {4'd0, VEC[i].go});
      chk($sformatf("R%0d vec%0d src", VEC[i].req, i), {4'd0, disp_src & disp_go},
          {4'd0, VEC[i].src});
    end

    // R10 reset asserted mid-cycle clears strobe at once
    drive(2'b01, 3'd2, 3'd0, 4'b0000);
    @(negedge clk);
    chk("R3 mem strobe before reset", {4'd0, disp_go}, 8'h04);
    #2 rst_n = 1'b0;
    #1;
    chk("R10 async clear go", {4'd0, disp_go}, 8'h00);
    chk("R10 async clear acc", {6'd0, slot_acc}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 accept resumes", {6'd0, slot_acc}, 8'h01);
    drive(2'b00, 3'd0, 3'd0, 4'b0000);
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule